// File: doc/BRIEF.md
# Banked Stack Pointer Selection Unit

This block keeps the two stack pointers of a microcontroller-class core, a main pointer and a process pointer, and decides which of them the core is currently using. One physical register always holds the live pointer and the other holds the stored copy. Whenever the selection changes, the two values are exchanged. The process pointer is live only in thread mode with the stack-select bit set. Handler mode, meaning a nonzero current exception number, always runs on the main pointer.

The stack-select bit is kept apart from the live pointer. It may remain set inside a handler without any effect, and the exchange happens only when the mode or the bit actually changes which pointer is in use.

Several sources update the state:
- exception entry clears the select bit;
- exception return loads the bit from the return value while the core is still in handler mode;
- software control writes change the bit only in thread mode, and always update the unprivileged flag;
- a separate write of the exception number moves the core in and out of handler mode.

The core reads and writes the live pointer through a dedicated port. Either pointer can also be read or written by name.

Top module: `stack_bank_unit`

## Requirements
- R1: `pspActive` is 1 exactly when the core is in thread mode (exception number 0) and `stackSel` is 1. In that state `spRdData` returns the process pointer; otherwise it returns the main pointer.
- R2: In handler mode the main pointer is live even when `stackSel` is 1. Writing a nonzero exception number while `stackSel` is 1 leaves `stackSel` at 1 and makes `spRdData` show the main pointer.
- R3: The two pointer values are exchanged only when the live selection changes. A select-bit or exception-number update that keeps the same pointer live leaves `spRdData` and both named reads unchanged.
- R4: A write (`excWrEn`) of a nonzero value enters handler mode (`handlerMode`=1). A write of zero returns to thread mode. Both take effect on the next clock edge.
- R5: `excEntry` clears `stackSel` to 0. It has priority over `excExit` and over control writes in the same cycle.
- R6: `excExit` loads `stackSel` from `excExitSel`. While the exception number stays nonzero, the live pointer does not change. The switch happens at the later write of exception number 0.
- R7: A control write (`ctrlWrEn`) made in handler mode leaves `stackSel` unchanged, whatever the value of `ctrlWrSel`.
- R8: Every control write loads `unprivFlag` from `ctrlWrUnpriv`, in either mode.
- R9: `namedRdData` returns the main pointer when `namedSel`=0 and the process pointer when `namedSel`=1, whichever is live. `namedWrEn` writes the named pointer. An active write in the same cycle to the same pointer wins.
- R10: Every pointer write forces bits [1:0] of the stored value to 0.
- R11: After reset both pointers are 0, `stackSel` and `unprivFlag` are 0, and the exception number is 0 (thread mode).
- R12: When `spWrEn` and a change of live selection fall in the same cycle, the written value lands in the pointer that was live before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| excWrEn | input | 1 | Write strobe for the current exception number |
| excWrNum | input | EXC_W | New exception number; zero means thread mode |
| excEntry | input | 1 | Exception entry strobe; clears the select bit |
| excExit | input | 1 | Exception return strobe; loads the select bit |
| excExitSel | input | 1 | Select-bit value carried by the return |
| ctrlWrEn | input | 1 | Software control-register write strobe |
| ctrlWrSel | input | 1 | Select-bit value of the control write |
| ctrlWrUnpriv | input | 1 | Unprivileged-flag value of the control write |
| spWrEn | input | 1 | Write strobe for the live pointer |
| spWrData | input | DATA_W | Data for the live pointer |
| spRdData | output | DATA_W | Live pointer value |
| namedSel | input | 1 | Pointer chosen by name: 0 main, 1 process |
| namedWrEn | input | 1 | Write strobe for the named pointer |
| namedWrData | input | DATA_W | Data for the named pointer |
| namedRdData | output | DATA_W | Value of the named pointer |
| stackSel | output | 1 | Current stack-select bit |
| unprivFlag | output | 1 | Current unprivileged flag |
| handlerMode | output | 1 | 1 while the exception number is nonzero |
| pspActive | output | 1 | 1 while the process pointer is live |

## Verification
Every state update is registered on the single clock edge that follows the strobe, so `stackSel`, `handlerMode`, `pspActive` and `spRdData` are each due exactly one cycle after their stimulus. `namedRdData` is combinational from `namedSel` on top of the stored state.

The bench applies each stimulus just after a falling edge and samples on the next falling edge, half a period after the edge that commits it. It then releases the strobes before the following rising edge.

The deferred switch on exception return is checked in two steps. The bench checks after the exit strobe that the live pointer is unchanged, and checks again after the exception-number write that the switch has happened.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  // Strobes passed from the selection control to the pointer datapath
  typedef struct packed {
    logic swap;        // exchange live and stored pointer this edge
    logic wrActiveSp;  // live pointer takes spWrData
    logic wrActiveNm;  // live pointer takes namedWrData
    logic wrOtherNm;   // stored pointer takes namedWrData
    logic rdActive;    // named read hits the live pointer
  } sbuStrobe_t;
endpackage

// File: rtl/sbu_select_ctrl.sv
module sbu_select_ctrl
  import sbu_pkg::*;
#(
  parameter int EXC_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excWrEn,
  input  logic [EXC_W-1:0] excWrNum,
  input  logic             excEntry,
  input  logic             excExit,
  input  logic             excExitSel,
  input  logic             ctrlWrEn,
  input  logic             ctrlWrSel,
  input  logic             ctrlWrUnpriv,
  input  logic             spWrEn,
  input  logic             namedSel,
  input  logic             namedWrEn,
  output sbuStrobe_t       strobe,
  output logic             stackSel,
  output logic             unprivFlag,
  output logic             handlerMode,
  output logic             pspActive
);
  localparam logic [EXC_W-1:0] THREAD_NUM = '0;

  logic [EXC_W-1:0] excNum, excNext;
  logic             selNext, unprivNext, pspNext;

  assign handlerMode = (excNum != THREAD_NUM);
  assign pspActive   = !handlerMode && stackSel;

  always_comb begin
    // select-bit sources in priority order
    if (excEntry)                      selNext = 1'b0;
    else if (excExit)                  selNext = excExitSel;
    else if (ctrlWrEn && !handlerMode) selNext = ctrlWrSel;
    else                               selNext = stackSel;
    unprivNext = ctrlWrEn ? ctrlWrUnpriv : unprivFlag;
    excNext    = excWrEn ? excWrNum : excNum;
    pspNext    = (excNext == THREAD_NUM) && selNext;
  end

  always_comb begin
    strobe.swap       = (pspNext != pspActive);
    strobe.rdActive   = (namedSel == pspActive);
    strobe.wrActiveSp = spWrEn;
    strobe.wrActiveNm = namedWrEn && strobe.rdActive && !spWrEn;
    strobe.wrOtherNm  = namedWrEn && !strobe.rdActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excNum     <= THREAD_NUM;
      stackSel   <= 1'b0;
      unprivFlag <= 1'b0;
    end else begin
      excNum     <= excNext;
      stackSel   <= selNext;
      unprivFlag <= unprivNext;
    end
  end
endmodule

// File: rtl/sbu_pointer_path.sv
module sbu_pointer_path
  import sbu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbuStrobe_t        strobe,
  input  logic [DATA_W-1:0] spWrData,
  input  logic [DATA_W-1:0] namedWrData,
  output logic [DATA_W-1:0] spRdData,
  output logic [DATA_W-1:0] namedRdData
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = {{(DATA_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [DATA_W-1:0] liveSp, storedSp;
  logic [DATA_W-1:0] liveVal, storedVal;

  always_comb begin
    // writes apply to the pointer live before any exchange
    if (strobe.wrActiveSp)      liveVal = spWrData & ALIGN_MASK;
    else if (strobe.wrActiveNm) liveVal = namedWrData & ALIGN_MASK;
    else                        liveVal = liveSp;
    storedVal = strobe.wrOtherNm ? (namedWrData & ALIGN_MASK) : storedSp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveSp   <= '0;
      storedSp <= '0;
    end else if (strobe.swap) begin
      liveSp   <= storedVal;
      storedSp <= liveVal;
    end else begin
      liveSp   <= liveVal;
      storedSp <= storedVal;
    end
  end

  assign spRdData    = liveSp;
  assign namedRdData = strobe.rdActive ? liveSp : storedSp;
endmodule

// File: rtl/stack_bank_unit.sv
module stack_bank_unit
  import sbu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2,
  parameter int EXC_W      = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excWrEn,
  input  logic [EXC_W-1:0]  excWrNum,
  input  logic              excEntry,
  input  logic              excExit,
  input  logic              excExitSel,
  input  logic              ctrlWrEn,
  input  logic              ctrlWrSel,
  input  logic              ctrlWrUnpriv,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWrData,
  output logic [DATA_W-1:0] spRdData,
  input  logic              namedSel,
  input  logic              namedWrEn,
  input  logic [DATA_W-1:0] namedWrData,
  output logic [DATA_W-1:0] namedRdData,
  output logic              stackSel,
  output logic              unprivFlag,
  output logic              handlerMode,
  output logic              pspActive
);
  sbuStrobe_t strobe;

  sbu_select_ctrl #(.EXC_W(EXC_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .excWrEn(excWrEn), .excWrNum(excWrNum),
    .excEntry(excEntry), .excExit(excExit), .excExitSel(excExitSel),
    .ctrlWrEn(ctrlWrEn), .ctrlWrSel(ctrlWrSel), .ctrlWrUnpriv(ctrlWrUnpriv),
    .spWrEn(spWrEn), .namedSel(namedSel), .namedWrEn(namedWrEn),
    .strobe(strobe), .stackSel(stackSel), .unprivFlag(unprivFlag),
    .handlerMode(handlerMode), .pspActive(pspActive)
  );

  sbu_pointer_path #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .spWrData(spWrData), .namedWrData(namedWrData),
    .spRdData(spRdData), .namedRdData(namedRdData)
  );
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              excWrEn,
  input logic              excEntry,
  input logic              excExit,
  input logic              excExitSel,
  input logic              ctrlWrEn,
  input logic              spWrEn,
  input logic              namedWrEn,
  input logic [DATA_W-1:0] spRdData,
  input logic              stackSel,
  input logic              handlerMode,
  input logic              pspActive
);
  // R2
  handler_uses_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    handlerMode |-> !pspActive);

  // R3
  no_swap_when_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!spWrEn && !namedWrEn) |=> ($stable(pspActive) -> $stable(spRdData)));

  // R5
  entry_clears_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    excEntry |=> !stackSel);

  // R6
  exit_defers_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excExit && !excEntry && handlerMode && !excWrEn) |=>
      (stackSel == $past(excExitSel)) && !pspActive);

  // R7
  handler_ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && handlerMode && !excEntry && !excExit) |=> $stable(stackSel));

  // R10
  always @(negedge clk) begin
    if (rstN) begin
      sp_aligned_chk: assert (spRdData[ALIGN_BITS-1:0] == '0);
    end
  end
endmodule

bind stack_bank_unit sbu_checker #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) i_sbu_checker (
  .clk(clk), .rstN(rstN), .excWrEn(excWrEn), .excEntry(excEntry),
  .excExit(excExit), .excExitSel(excExitSel), .ctrlWrEn(ctrlWrEn),
  .spWrEn(spWrEn), .namedWrEn(namedWrEn), .spRdData(spRdData),
  .stackSel(stackSel), .handlerMode(handlerMode), .pspActive(pspActive)
);

// File: tb/test_stack_bank_unit.sv
module test_stack_bank_unit;
  localparam int DATA_W = 32;
  localparam int EXC_W  = 9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              excWrEn = 0, excEntry = 0, excExit = 0, excExitSel = 0;
  logic [EXC_W-1:0]  excWrNum = '0;
  logic              ctrlWrEn = 0, ctrlWrSel = 0, ctrlWrUnpriv = 0;
  logic              spWrEn = 0, namedSel = 0, namedWrEn = 0;
  logic [DATA_W-1:0] spWrData = '0, namedWrData = '0;
  logic [DATA_W-1:0] spRdData, namedRdData;
  logic              stackSel, unprivFlag, handlerMode, pspActive;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  stack_bank_unit i_stack_bank_unit (
    .clk(clk), .rstN(rstN),
    .excWrEn(excWrEn), .excWrNum(excWrNum),
    .excEntry(excEntry), .excExit(excExit), .excExitSel(excExitSel),
    .ctrlWrEn(ctrlWrEn), .ctrlWrSel(ctrlWrSel), .ctrlWrUnpriv(ctrlWrUnpriv),
    .spWrEn(spWrEn), .spWrData(spWrData), .spRdData(spRdData),
    .namedSel(namedSel), .namedWrEn(namedWrEn), .namedWrData(namedWrData),
    .namedRdData(namedRdData),
    .stackSel(stackSel), .unprivFlag(unprivFlag),
    .handlerMode(handlerMode), .pspActive(pspActive)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one commit edge, then release all strobes; caller sits on a falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    excWrEn = 0; excEntry = 0; excExit = 0; ctrlWrEn = 0;
    spWrEn = 0; namedWrEn = 0;
  endtask

  task automatic readNamed(input logic which, output logic [DATA_W-1:0] v);
    namedSel = which;
    #1 v = namedRdData;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    check("R11 sp", spRdData, 0);
    check("R11 sel", {31'd0, stackSel}, 0);
    check("R11 unpriv", {31'd0, unprivFlag}, 0);
    check("R11 handler", {31'd0, handlerMode}, 0);
    readNamed(1'b1, v); check("R11 process", v, 0);
  endtask

  task automatic t_thread_writes();
    logic [DATA_W-1:0] v;
    spWrEn = 1; spWrData = 32'h0000_1003; step();
    check("R10 main aligned", spRdData, 32'h1000);
    ctrlWrEn = 1; ctrlWrSel = 1; ctrlWrUnpriv = 0; step();
    check("R1 psp active", {31'd0, pspActive}, 1);
    check("R1 sp is process", spRdData, 0);
    spWrEn = 1; spWrData = 32'h0000_2002; step();
    check("R10 process aligned", spRdData, 32'h2000);
    readNamed(1'b0, v); check("R9 main by name", v, 32'h1000);
    readNamed(1'b1, v); check("R9 process by name", v, 32'h2000);
    ctrlWrEn = 1; ctrlWrSel = 1; step();
    check("R3 same select no swap", spRdData, 32'h2000);
  endtask

  task automatic t_exception_cycle();
    logic [DATA_W-1:0] v;
    excEntry = 1; excWrEn = 1; excWrNum = 9'd5; step();
    check("R4 handler", {31'd0, handlerMode}, 1);
    check("R5 sel cleared", {31'd0, stackSel}, 0);
    check("R1 main live", spRdData, 32'h1000);
    ctrlWrEn = 1; ctrlWrSel = 1; ctrlWrUnpriv = 1; step();
    check("R7 sel ignored", {31'd0, stackSel}, 0);
    check("R8 unpriv in handler", {31'd0, unprivFlag}, 1);
    check("R7 sp unchanged", spRdData, 32'h1000);
    excExit = 1; excExitSel = 1; step();
    check("R6 sel loaded", {31'd0, stackSel}, 1);
    check("R6 sp deferred", spRdData, 32'h1000);
    readNamed(1'b1, v); check("R9 stored process", v, 32'h2000);
    excWrEn = 1; excWrNum = '0; spWrEn = 1; spWrData = 32'h1500; step();
    check("R4 thread", {31'd0, handlerMode}, 0);
    check("R6 switched", spRdData, 32'h2000);
    readNamed(1'b0, v); check("R12 write hit old live", v, 32'h1500);
  endtask

  task automatic t_handler_with_sel();
    excWrEn = 1; excWrNum = 9'd3; step();
    check("R2 sel kept", {31'd0, stackSel}, 1);
    check("R2 main live", spRdData, 32'h1500);
    check("R2 not psp", {31'd0, pspActive}, 0);
    excWrEn = 1; excWrNum = '0; step();
    check("R4 back to process", spRdData, 32'h2000);
  endtask

  task automatic t_named_and_priv();
    logic [DATA_W-1:0] v;
    ctrlWrEn = 1; ctrlWrSel = 0; ctrlWrUnpriv = 0; step();
    check("R1 main after clear", spRdData, 32'h1500);
    check("R8 unpriv cleared", {31'd0, unprivFlag}, 0);
    namedSel = 1; namedWrEn = 1; namedWrData = 32'h3007; step();
    check("R9 live untouched", spRdData, 32'h1500);
    readNamed(1'b1, v); check("R9 process written", v, 32'h3004);
    namedSel = 0; namedWrEn = 1; namedWrData = 32'h4000;
    spWrEn = 1; spWrData = 32'h5000; step();
    check("R9 active write wins", spRdData, 32'h5000);
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_thread_writes();
    t_exception_cycle();
    t_handler_with_sel();
    t_named_and_priv();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule